// File: doc/BRIEF.md
# Sweep Dwell-Point Statistics Engine

This block sits in a test fixture that exercises an analog front-end with a linear calibration sweep. At every dwell point of the sweep the fixture takes a fixed batch of ADC readings. The block keeps those readings in a local sample RAM and reduces each batch to two numbers: a centroid (the mean) and a noise figure (the variance). Noise is therefore measured at every step of the sweep, not at a single operating point.

A dwell point is opened with a start pulse. Exactly 256 samples of 12 bits each are then collected, and the point is closed with an end pulse. The running sum is built as samples arrive. After the end pulse, a reduction pass reads the RAM back and squares each stored sample to form the sum of squares. A shift-add multiplier then forms the square of the mean. The result is held on a valid/ready output together with a 16-bit sequence index. An early end discards the point. A start that arrives while the engine is busy is reported as an overrun.

Top module: `dwell_stat_engine`

## Requirements
- R1: After reset, res_valid_o, short_o and overrun_o are 0 and res_index_o is 0.
- R2: For a complete point, res_mean_o equals floor(S/256), where S is the sum of the 256 samples taken.
- R3: For a complete point, res_var_o equals floor(Q/256) - mean*mean, where Q is the sum of the squares of the 256 samples. The value is 24 bits wide.
- R4: While res_valid_o is 1 and res_ready_i is 0, res_valid_o stays 1 and res_mean_o, res_var_o and res_index_o hold their values. A cycle with both at 1 retires the result.
- R5: The first result carries index 0. res_index_o increases by one on each retired result.
- R6: An end pulse in a point with fewer than 256 samples raises short_o for exactly one cycle, in the cycle after the end, and produces no result.
- R7: Samples that arrive after the 256th sample and before the end pulse are ignored.
- R8: A start pulse while a result is pending (and res_ready_i is 0) or while a point is being reduced raises overrun_o for one cycle and is dropped. The later samples and end pulse of that point produce neither a result nor short_o.
- R9: A start pulse in the same cycle as a result handshake is accepted, and overrun_o stays 0.
- R10: A start pulse during collection restarts the point and discards the samples already taken.
- R11: Samples outside a collecting point are ignored, and so is a sample presented in the same cycle as the start pulse.
- R12: An end pulse while no point is open has no effect: short_o stays 0 and no result appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dwell_start_i | input | 1 | Opens a dwell point |
| dwell_end_i | input | 1 | Closes the open dwell point |
| sample_valid_i | input | 1 | sample_i carries an ADC reading |
| sample_i | input | 12 | ADC reading |
| res_ready_i | input | 1 | Host accepts the pending result |
| res_valid_o | output | 1 | A result is pending |
| res_mean_o | output | 12 | Centroid of the point |
| res_var_o | output | 24 | Variance of the point |
| res_index_o | output | 16 | Sequence index of the result |
| short_o | output | 1 | One-cycle pulse: point ended with too few samples |
| overrun_o | output | 1 | One-cycle pulse: start pulse dropped |

## Verification
A host handshake and the start of the next dwell point can fall in the same cycle. The same start pulse is accepted when res_ready_i is high and counted as an overrun when it is low. The bench raises dwell_start_i in a cycle with a result pending, once with res_ready_i low and once with it high. It then checks overrun_o, res_valid_o and res_index_o after that edge. It also feeds a full point after each of these starts, to show whether the start was taken: the dropped case must leave the old result and index untouched, and the accepted case must yield the next index with correct statistics.

// File: rtl/dwell_stat_pkg.sv
package dwell_stat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_SQUARE,
    ST_MSQ,
    ST_RESULT
  } dwell_state_e;
endpackage

// File: rtl/dwell_sample_ram.sv
module dwell_sample_ram #(
  parameter int DW = 12,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dwell_seq_mult.sv
module dwell_seq_mult #(
  parameter int W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int CW = $clog2(W + 1);

  logic [2*W-1:0] acc_q, mcand_q;
  logic [W-1:0]   mplier_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q    <= '0;
        mcand_q  <= {{W{1'b0}}, a_i};
        mplier_q <= b_i;
        cnt_q    <= CW'(W);
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        if (mplier_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/dwell_stat_engine.sv
module dwell_stat_engine
  import dwell_stat_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LOG2_N   = 8,
  parameter int IDX_W    = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dwell_start_i,
  input  logic                  dwell_end_i,
  input  logic                  sample_valid_i,
  input  logic [SAMPLE_W-1:0]   sample_i,
  input  logic                  res_ready_i,
  output logic                  res_valid_o,
  output logic [SAMPLE_W-1:0]   res_mean_o,
  output logic [2*SAMPLE_W-1:0] res_var_o,
  output logic [IDX_W-1:0]      res_index_o,
  output logic                  short_o,
  output logic                  overrun_o
);
  localparam int CNT_W = LOG2_N + 1;
  localparam int SUM_W = SAMPLE_W + LOG2_N;
  localparam int VAR_W = 2 * SAMPLE_W;
  localparam int SQ_W  = VAR_W + LOG2_N;

  dwell_state_e state_q;
  logic [CNT_W-1:0]    cnt_q, cnt_nxt, rd_ptr_q;
  logic [SUM_W-1:0]    sum_q;
  logic [SQ_W-1:0]     sumsq_q;
  logic [SAMPLE_W-1:0] mean_q, rd_data;
  logic [VAR_W-1:0]    var_q, rd_sq, msq;
  logic [IDX_W-1:0]    idx_q;
  logic                rd_v_q, short_q, ovr_q;
  logic                hs, start_ok, start_bad, take, end_evt, full, rd_en;
  logic                mult_start, mult_done;

  assign hs        = (state_q == ST_RESULT) && res_ready_i;
  assign start_ok  = dwell_start_i && (state_q == ST_IDLE || state_q == ST_COLLECT || hs);
  assign start_bad = dwell_start_i && !start_ok;
  assign take      = (state_q == ST_COLLECT) && !dwell_start_i && sample_valid_i && !cnt_q[LOG2_N];
  assign cnt_nxt   = cnt_q + {{(CNT_W-1){1'b0}}, take};
  assign end_evt   = (state_q == ST_COLLECT) && !dwell_start_i && dwell_end_i;
  assign full      = cnt_nxt[LOG2_N];
  assign rd_en     = (state_q == ST_SQUARE) && !rd_ptr_q[LOG2_N];
  assign mult_start = (state_q == ST_SQUARE) && rd_ptr_q[LOG2_N] && !rd_v_q;
  assign rd_sq     = VAR_W'(rd_data) * VAR_W'(rd_data);

  dwell_sample_ram #(.DW(SAMPLE_W), .AW(LOG2_N)) u_ram (
    .clk_i   (clk_i),
    .we_i    (take),
    .waddr_i (cnt_q[LOG2_N-1:0]),
    .wdata_i (sample_i),
    .raddr_i (rd_ptr_q[LOG2_N-1:0]),
    .rdata_o (rd_data)
  );

  dwell_seq_mult #(.W(SAMPLE_W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mult_start),
    .a_i     (sum_q[SUM_W-1:LOG2_N]),
    .b_i     (sum_q[SUM_W-1:LOG2_N]),
    .done_o  (mult_done),
    .prod_o  (msq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rd_ptr_q <= '0;
      sum_q    <= '0;
      sumsq_q  <= '0;
      mean_q   <= '0;
      var_q    <= '0;
      idx_q    <= '0;
      rd_v_q   <= 1'b0;
      short_q  <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      short_q <= end_evt && !full;
      ovr_q   <= start_bad;
      rd_v_q  <= rd_en;
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_COLLECT;
            cnt_q   <= '0;
            sum_q   <= '0;
          end
        end
        ST_COLLECT: begin
          if (start_ok) begin
            cnt_q <= '0;
            sum_q <= '0;
          end else begin
            if (take) begin
              cnt_q <= cnt_nxt;
              sum_q <= sum_q + SUM_W'(sample_i);
            end
            if (end_evt) begin
              if (full) begin
                state_q  <= ST_SQUARE;
                rd_ptr_q <= '0;
                sumsq_q  <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_SQUARE: begin
          if (rd_en) rd_ptr_q <= rd_ptr_q + CNT_W'(1);
          if (rd_v_q) sumsq_q <= sumsq_q + SQ_W'(rd_sq);
          if (mult_start) state_q <= ST_MSQ;
        end
        ST_MSQ: begin
          if (mult_done) begin
            mean_q  <= sum_q[SUM_W-1:LOG2_N];
            var_q   <= sumsq_q[SQ_W-1:LOG2_N] - msq;
            state_q <= ST_RESULT;
          end
        end
        ST_RESULT: begin
          if (hs) begin
            idx_q <= idx_q + IDX_W'(1);
            if (start_ok) begin
              state_q <= ST_COLLECT;
              cnt_q   <= '0;
              sum_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_valid_o = (state_q == ST_RESULT);
  assign res_mean_o  = mean_q;
  assign res_var_o   = var_q;
  assign res_index_o = idx_q;
  assign short_o     = short_q;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/dwell_stat_engine_chk.sv
module dwell_stat_engine_chk #(
  parameter int SAMPLE_W = 12,
  parameter int IDX_W    = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  dwell_start_i,
  input logic                  res_ready_i,
  input logic                  res_valid_o,
  input logic [SAMPLE_W-1:0]   res_mean_o,
  input logic [2*SAMPLE_W-1:0] res_var_o,
  input logic [IDX_W-1:0]      res_index_o,
  input logic                  short_o,
  input logic                  overrun_o
);
  a_r4_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_mean_o) &&
                                     $stable(res_var_o) && $stable(res_index_o));

  a_r5_index_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_ready_i |=> res_index_o == $past(res_index_o) + IDX_W'(1));

  a_r6_short_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |-> !res_valid_o);

  a_r6_short_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o |=> !short_o);

  a_r8_overrun_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwell_start_i && res_valid_o && !res_ready_i |=> overrun_o);

  a_r9_start_on_handshake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dwell_start_i && res_valid_o && res_ready_i |=> !overrun_o && !res_valid_o);
endmodule

bind dwell_stat_engine dwell_stat_engine_chk #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dwell_start_i (dwell_start_i),
  .res_ready_i   (res_ready_i),
  .res_valid_o   (res_valid_o),
  .res_mean_o    (res_mean_o),
  .res_var_o     (res_var_o),
  .res_index_o   (res_index_o),
  .short_o       (short_o),
  .overrun_o     (overrun_o)
);

// File: tb/dwell_stat_engine_bench.sv
`timescale 1ns/100ps
module dwell_stat_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dwell_start_i = 1'b0, dwell_end_i = 1'b0, sample_valid_i = 1'b0, res_ready_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        res_valid_o, short_o, overrun_o;
  logic [11:0] res_mean_o;
  logic [23:0] res_var_o;
  logic [15:0] res_index_o;

  dwell_stat_engine u_dwell_stat_engine (.*);

  always #2.5 clk_i = ~clk_i;

  // {base, step, modulus, hold cycles}: sample k = (base + (k*step) % modulus) & 12'hFFF
  localparam logic [47:0] VEC [5] = '{
    {12'd1000, 12'd0,    12'd1,    12'd0},
    {12'd0,    12'd1,    12'd256,  12'd3},
    {12'd4095, 12'd0,    12'd1,    12'd1},
    {12'd100,  12'd1000, 12'd2001, 12'd5},
    {12'd0,    12'd4095, 12'd4095, 12'd2}
  };

  int  n_chk = 0, n_fail = 0;
  int  exp_idx = 0;
  bit  finished = 0;

  function automatic logic [11:0] samp(int p, int k);
    longint b = VEC[p][47:36], s = VEC[p][35:24], m = VEC[p][23:12];
    return 12'((b + (longint'(k) * s) % m) & 'hFFF);
  endfunction

  function automatic longint exp_mean(int p);
    longint s = 0;
    for (int k = 0; k < 256; k++) s += samp(p, k);
    return s >> 8;
  endfunction

  function automatic longint exp_var(int p);
    longint q = 0, m;
    for (int k = 0; k < 256; k++) q += longint'(samp(p, k)) * samp(p, k);
    m = exp_mean(p);
    return (q >> 8) - m * m;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic pulse_start();
    dwell_start_i = 1'b1; tick(); dwell_start_i = 1'b0;
  endtask

  task automatic pulse_end();
    dwell_end_i = 1'b1; tick(); dwell_end_i = 1'b0;
  endtask

  task automatic feed(int p, int n);
    for (int k = 0; k < n; k++) begin
      sample_valid_i = 1'b1; sample_i = samp(p, k); tick();
    end
    sample_valid_i = 1'b0;
  endtask

  task automatic feed_const(logic [11:0] v, int n);
    for (int k = 0; k < n; k++) begin
      sample_valid_i = 1'b1; sample_i = v; tick();
    end
    sample_valid_i = 1'b0;
  endtask

  task automatic wait_valid(string req);
    int w = 0;
    while (!res_valid_o && w < 2000) begin tick(); w++; end
    check(res_valid_o, req, res_valid_o, 1);
  endtask

  task automatic check_result(int p, string req);
    check(res_mean_o == 12'(exp_mean(p)), {req, " R2 mean"}, res_mean_o, exp_mean(p));
    check(res_var_o == 24'(exp_var(p)), {req, " R3 variance"}, res_var_o, exp_var(p));
    check(res_index_o == 16'(exp_idx), {req, " R5 index"}, res_index_o, exp_idx);
  endtask

  task automatic retire();
    res_ready_i = 1'b1; tick(); res_ready_i = 1'b0;
    exp_idx++;
    check(!res_valid_o, "R4 retire", res_valid_o, 0);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check(!res_valid_o, "R1 valid", res_valid_o, 0);
    check(!short_o && !overrun_o, "R1 flags", {short_o, overrun_o}, 0);
    check(res_index_o == 0, "R1 index", res_index_o, 0);
    rst_ni = 1'b1;
    tick();

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < 5; i++) begin
      pulse_start();
      feed(i, 256);
      pulse_end();
      wait_valid("R2 table result");
      check_result(i, "table");
      for (int h = 0; h < int'(VEC[i][11:0]); h++) begin
        tick();
        check(res_valid_o && res_index_o == 16'(exp_idx) && res_mean_o == 12'(exp_mean(i)),
              "R4 hold", res_mean_o, exp_mean(i));
      end
      retire();
    end

    // R12: end with no open point
    pulse_end();
    check(!short_o, "R12 short", short_o, 0);
    tick();
    check(!res_valid_o, "R12 valid", res_valid_o, 0);

    // R6: early end
    pulse_start();
    feed(0, 10);
    pulse_end();
    check(short_o, "R6 short pulse", short_o, 1);
    tick();
    check(!short_o, "R6 short clears", short_o, 0);
    repeat (300) tick();
    check(!res_valid_o, "R6 no result", res_valid_o, 0);

    // R11: sample on start cycle; R10: restart; R7: extras after 256
    sample_valid_i = 1'b1; sample_i = 12'hFFF; pulse_start(); sample_valid_i = 1'b0;
    feed_const(12'hFFF, 50);
    sample_valid_i = 1'b1; sample_i = 12'hFFF; pulse_start(); sample_valid_i = 1'b0;
    feed(3, 256);
    feed_const(12'hFFF, 44);
    pulse_end();
    wait_valid("R10 restart result");
    check_result(3, "R7 R10 R11");

    // R8: start while result pending, ready low
    pulse_start();
    check(overrun_o, "R8 overrun", overrun_o, 1);
    tick();
    check(!overrun_o, "R8 overrun pulse", overrun_o, 0);
    feed(0, 256);
    pulse_end();
    check(!short_o, "R8 no short", short_o, 0);
    repeat (300) tick();
    check(res_valid_o && res_index_o == 16'(exp_idx) && res_mean_o == 12'(exp_mean(3)),
          "R8 old result kept", res_mean_o, exp_mean(3));

    // R9: start together with handshake
    dwell_start_i = 1'b1; res_ready_i = 1'b1; tick();
    dwell_start_i = 1'b0; res_ready_i = 1'b0; exp_idx++;
    check(!overrun_o, "R9 no overrun", overrun_o, 0);
    check(!res_valid_o, "R9 retired", res_valid_o, 0);
    feed(1, 256);
    pulse_end();
    wait_valid("R9 result");
    check_result(1, "R9");
    retire();

    repeat (3) tick();
    summary();
  end
endmodule